// File: doc/BRIEF.md
# Two-Button Shutdown Controller for a Stepped Potentiometer

This block sits between the active-low up, down and store-enable buttons of a push-button potentiometer and the step logic that moves its wiper. It decides when the potentiometer enters a low-power shutdown state and when it leaves it. The 1 ms time base is a one-cycle tick supplied from outside.

To enter shutdown, both step buttons must go low close together in time and then stay low together. On entry the block records the wiper position supplied by the step logic. It forces the effective position to tap 0 and raises a flag that disconnects the top terminal of the resistor chain. A later qualifying low on any of the three buttons ends shutdown. At that point the block strobes the recorded position back to the step logic. If the button that ended shutdown is still held, the block signals when the step logic should begin auto-repeating in that button's direction.

While the block owns the buttons, it raises a hold output. This tells the step logic to ignore the buttons: during a two-button press, after a misaligned press, during shutdown and while it waits after an exit.

Top module: `shdn_ctrl`

## Requirements
- R1: After reset `shdn_o`, `restore_o`, `repeat_o` and `hold_o` are 0, and `pos_o` equals `pos_i`.
- R2: If the second step button goes low fewer than ALIGN_MS ticks after the first, and both then stay low for ENTRY_MS ticks, `shdn_o` rises to 1 and `pos_o` becomes 0. Both buttons going low in the same cycle also counts.
- R3: If the second step button goes low ALIGN_MS or more ticks after the first, shutdown is never entered, however long both are held. `hold_o` stays 1 until both step buttons are high again.
- R4: If either step button is released before the ENTRY_MS hold completes, shutdown is not entered. `hold_o` stays 1 until both step buttons are high again.
- R5: The position recorded at entry is `pos_i` in the entry cycle. `restore_pos_o` shows it, and no change of `pos_i` or of the buttons alters it during shutdown.
- R6: Buttons still held from entry never end shutdown. Releasing them does not end it either.
- R7: Once all buttons have been released after entry, holding any of up, down or store low for EXIT_MS consecutive ticks ends shutdown. A shorter low has no effect.
- R8: At exit `shdn_o` falls and `restore_o` pulses high for one cycle in that same cycle. In that cycle `pos_o` equals the recorded position.
- R9: Exit can be caused by a single step button. If that button then stays low for REPEAT_MS more ticks, `repeat_o` pulses for one cycle, with `repeat_up_o` = 1 for up and 0 for down. A release before that gives no pulse.
- R10: `hold_o` is 0 when idle and during a single-button press. It is 1 during shutdown and during any two-button press.
- R11: `shdn_o` and `pos_o` change in the same clock cycle on both entry and exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| up_n | input | 1 | Up button, active low |
| dn_n | input | 1 | Down button, active low |
| store_n | input | 1 | Store-enable button, active low |
| pos_i | input | POS_W | Wiper position from the step logic |
| shdn_o | output | 1 | Shutdown flag; disconnects the top terminal |
| pos_o | output | POS_W | Effective wiper position |
| restore_o | output | 1 | One-cycle strobe: step logic loads `restore_pos_o` |
| restore_pos_o | output | POS_W | Position recorded at entry |
| hold_o | output | 1 | Step logic must ignore the buttons |
| repeat_o | output | 1 | One-cycle strobe: start auto-repeat |
| repeat_up_o | output | 1 | Repeat direction, 1 = up |

## Verification
The hardest situation to reach is the one where shutdown must be left with the recorded position while the step logic is presenting a different one. The bench first drives an aligned two-button press through the full entry hold. It then releases both buttons, changes `pos_i`, and applies a short low that must not count. Only after that does it apply a qualifying store or step press. A scoreboard queue holds the expected entry, exit and repeat events with their positions and directions. The monitor checks each event against the ports in the cycle it appears, including whether `pos_o` shows the recorded value in the exit cycle.

// File: rtl/shdn_pkg.sv
package shdn_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,    // no step button low
      ST_ONE,     // one step button low, alignment window running
      ST_BOTH,    // both low and aligned, entry hold running
      ST_BLOCK,   // misaligned or aborted, wait for full release
      ST_ENTERED, // in shutdown, waiting for all buttons high
      ST_SHDN,    // in shutdown, watching for a qualifying low
      ST_REARM,   // exited by a step button, repeat delay running
      ST_PASS     // repeat handed to step logic, wait for release
   } shdn_state_e;
endpackage

// File: rtl/shdn_timer.sv
module shdn_timer #(
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (clr)                 cnt <= '0;
      else if (tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   // count only grows between clears
   assert_timer_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/shdn_fsm.sv
module shdn_fsm
   import shdn_pkg::*;
#(
   parameter int POS_W     = 5,
   parameter int CW        = 11,
   parameter int ALIGN_MS  = 15,
   parameter int ENTRY_MS  = 2000,
   parameter int EXIT_MS   = 15,
   parameter int REPEAT_MS = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             up,
   input  logic             dn,
   input  logic             st,
   input  logic [POS_W-1:0] pos_i,
   input  logic [CW-1:0]    cnt,
   output logic             clr,
   output logic             shdn_q,
   output logic             rst_stb_q,
   output logic             rep_q,
   output logic             rep_dir_q,
   output logic [POS_W-1:0] saved_q,
   output logic             hold
);
   localparam logic [CW-1:0] ALIGN_C  = CW'(ALIGN_MS);
   localparam logic [CW-1:0] ENTRY_C  = CW'(ENTRY_MS - 1);
   localparam logic [CW-1:0] EXIT_C   = CW'(EXIT_MS - 1);
   localparam logic [CW-1:0] REPEAT_C = CW'(REPEAT_MS - 1);

   shdn_state_e state, nxt;
   logic enter, leave, fire, nxt_dir, any_step, all_btn;

   assign any_step = up | dn;
   assign all_btn  = up | dn | st;

   always_comb begin
      nxt     = state;
      enter   = 1'b0;
      leave   = 1'b0;
      fire    = 1'b0;
      nxt_dir = rep_dir_q;
      clr     = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (up && dn)      nxt = ST_BOTH;
            else if (any_step) nxt = ST_ONE;
         end
         ST_ONE: begin
            if (!any_step)          nxt = ST_IDLE;
            else if (up && dn)      nxt = (cnt < ALIGN_C) ? ST_BOTH : ST_BLOCK;
         end
         ST_BOTH: begin
            if (!(up && dn))               nxt = ST_BLOCK;
            else if (tick && cnt == ENTRY_C) begin
               nxt   = ST_ENTERED;
               enter = 1'b1;
            end
         end
         ST_BLOCK: begin
            if (!any_step) nxt = ST_IDLE;
         end
         ST_ENTERED: begin
            if (!all_btn) nxt = ST_SHDN;
         end
         ST_SHDN: begin
            if (!all_btn) clr = 1'b1;
            else if (tick && cnt == EXIT_C) begin
               leave = 1'b1;
               if (up && dn)  nxt = ST_BLOCK;
               else if (up) begin nxt = ST_REARM; nxt_dir = 1'b1; end
               else if (dn) begin nxt = ST_REARM; nxt_dir = 1'b0; end
               else           nxt = ST_IDLE;
            end
         end
         ST_REARM: begin
            if (rep_dir_q ? (!up || dn) : (!dn || up))
               nxt = any_step ? ST_BLOCK : ST_IDLE;
            else if (tick && cnt == REPEAT_C) begin
               nxt  = ST_PASS;
               fire = 1'b1;
            end
         end
         ST_PASS: begin
            if (!any_step) nxt = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
      if (nxt != state) clr = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         shdn_q    <= 1'b0;
         rst_stb_q <= 1'b0;
         rep_q     <= 1'b0;
         rep_dir_q <= 1'b0;
         saved_q   <= '0;
      end else begin
         state     <= nxt;
         rst_stb_q <= leave;
         rep_q     <= fire;
         rep_dir_q <= nxt_dir;
         if (enter) begin
            shdn_q  <= 1'b1;
            saved_q <= pos_i;
         end else if (leave) begin
            shdn_q  <= 1'b0;
         end
      end
   end

   assign hold = !(state == ST_IDLE || state == ST_ONE || state == ST_PASS);

   assert_entry_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shdn_q) |-> saved_q == $past(pos_i));
   assert_saved_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_q |=> $stable(saved_q));
   assert_entry_both_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shdn_q) |-> $past(up && dn));
   assert_exit_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shdn_q) |-> rst_stb_q);
   assert_repeat_after_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rep_q |-> !shdn_q && $past(!shdn_q));
   assert_strobes_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rep_q, rst_stb_q}));
   assert_hold_in_shdn_R10: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_q |-> hold);
endmodule

// File: rtl/shdn_ctrl.sv
module shdn_ctrl #(
   parameter int POS_W     = 5,
   parameter int ALIGN_MS  = 15,
   parameter int ENTRY_MS  = 2000,
   parameter int EXIT_MS   = 15,
   parameter int REPEAT_MS = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_ms,
   input  logic             up_n,
   input  logic             dn_n,
   input  logic             store_n,
   input  logic [POS_W-1:0] pos_i,
   output logic             shdn_o,
   output logic [POS_W-1:0] pos_o,
   output logic             restore_o,
   output logic [POS_W-1:0] restore_pos_o,
   output logic             hold_o,
   output logic             repeat_o,
   output logic             repeat_up_o
);
   localparam int MAX_AB = (ALIGN_MS > ENTRY_MS) ? ALIGN_MS : ENTRY_MS;
   localparam int MAX_CD = (EXIT_MS > REPEAT_MS) ? EXIT_MS : REPEAT_MS;
   localparam int MAX_L  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CW     = $clog2(MAX_L + 1);

   generate
      if (POS_W < 1 || POS_W > 16)
         $error("shdn_ctrl: POS_W out of range");
      if (ALIGN_MS < 1 || ENTRY_MS < 2 || EXIT_MS < 1 || REPEAT_MS < 1)
         $error("shdn_ctrl: timing limits must be positive");
      if (ALIGN_MS >= ENTRY_MS)
         $error("shdn_ctrl: alignment window must be shorter than entry hold");
   endgenerate

   logic          clr;
   logic [CW-1:0] cnt;
   logic          shdn_q, rst_stb_q;
   logic [POS_W-1:0] saved_q;

   shdn_timer #(.CW(CW)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .tick (tick_ms),
      .cnt  (cnt)
   );

   shdn_fsm #(
      .POS_W    (POS_W),
      .CW       (CW),
      .ALIGN_MS (ALIGN_MS),
      .ENTRY_MS (ENTRY_MS),
      .EXIT_MS  (EXIT_MS),
      .REPEAT_MS(REPEAT_MS)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_ms),
      .up       (~up_n),
      .dn       (~dn_n),
      .st       (~store_n),
      .pos_i    (pos_i),
      .cnt      (cnt),
      .clr      (clr),
      .shdn_q   (shdn_q),
      .rst_stb_q(rst_stb_q),
      .rep_q    (repeat_o),
      .rep_dir_q(repeat_up_o),
      .saved_q  (saved_q),
      .hold     (hold_o)
   );

   assign shdn_o        = shdn_q;
   assign restore_o     = rst_stb_q;
   assign restore_pos_o = saved_q;
   assign pos_o         = shdn_q ? '0 : (rst_stb_q ? saved_q : pos_i);

   assert_restore_pos_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shdn_o) |-> pos_o == restore_pos_o);
   assert_zero_on_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shdn_o) |-> pos_o == '0);
endmodule

// File: tb/shdn_ctrl_test.sv
module shdn_ctrl_test;
   localparam int W = 5;
   localparam int ENTRY = 2000;
   localparam int REP = 250;

   logic clk = 1'b0, rst_n = 1'b0, tick_ms = 1'b0;
   logic up_n = 1'b1, dn_n = 1'b1, store_n = 1'b1;
   logic [W-1:0] pos_i = 5'd9;
   logic shdn_o, restore_o, hold_o, repeat_o, repeat_up_o;
   logic [W-1:0] pos_o, restore_pos_o;

   int checks = 0, errors = 0;
   int exp_q[$];  // kind*256 + value : 1 entry, 2 exit(pos), 3 repeat(dir)
   logic prev_shdn = 1'b0;
   bit done = 0;

   always #4 clk = ~clk;  // 125 MHz

   shdn_ctrl uut (
      .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .up_n(up_n), .dn_n(dn_n),
      .store_n(store_n), .pos_i(pos_i), .shdn_o(shdn_o), .pos_o(pos_o),
      .restore_o(restore_o), .restore_pos_o(restore_pos_o), .hold_o(hold_o),
      .repeat_o(repeat_o), .repeat_up_o(repeat_up_o)
   );

   // one tick every two cycles: 1 ms == 2 cycles
   initial forever begin
      @(negedge clk);
      tick_ms = rst_n ? ~tick_ms : 1'b0;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ms(input int n);
      repeat (2 * n) @(negedge clk);
   endtask

   task automatic expect_ev(input int kind, input int val);
      exp_q.push_back(kind * 256 + val);
   endtask

   task automatic pop_cmp(input string req, input int got);
      if (exp_q.size() == 0) chk(req, got, -1);
      else chk(req, got, exp_q.pop_front());
   endtask

   // monitor: compares events against the scoreboard queue
   initial forever begin
      @(negedge clk);
      if (rst_n) begin
         if (shdn_o && !prev_shdn) begin
            pop_cmp("R2 entry", 256);
            chk("R11 pos zero at entry", pos_o, 0);
         end
         if (!shdn_o && prev_shdn) chk("R8 strobe with fall", restore_o, 1);
         if (restore_o) begin
            pop_cmp("R8 exit", 512 + pos_o);
            chk("R8 restore value", pos_o, restore_pos_o);
         end
         if (repeat_o) pop_cmp("R9 repeat", 768 + repeat_up_o);
         prev_shdn = shdn_o;
      end
   end

   // aligned entry: second button 5 ms after the first
   task automatic enter_shdn(input int p);
      pos_i = W'(p);
      expect_ev(1, 0);
      up_n = 1'b0; wait_ms(5);
      dn_n = 1'b0; wait_ms(ENTRY - 3);
      chk("R2 not yet in shutdown", shdn_o, 0);
      wait_ms(6);
      chk("R2 shutdown entered", shdn_o, 1);
      chk("R2 pos forced zero", pos_o, 0);
      up_n = 1'b1; dn_n = 1'b1; wait_ms(5);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 shdn reset", shdn_o, 0);
      chk("R1 pos follows", pos_o, 9);
      chk("R1 hold reset", hold_o, 0);
      chk("R1 strobes reset", restore_o | repeat_o, 0);
      rst_n = 1'b1;
      wait_ms(3);

      // single press: step logic owns it
      up_n = 1'b0; wait_ms(100);
      chk("R10 hold low single press", hold_o, 0);
      up_n = 1'b1; wait_ms(5);

      // misaligned press
      up_n = 1'b0; wait_ms(30);
      dn_n = 1'b0; wait_ms(ENTRY + 100);
      chk("R3 misaligned no shutdown", shdn_o, 0);
      chk("R3 hold while misaligned", hold_o, 1);
      dn_n = 1'b1; wait_ms(5);
      chk("R3 hold until both released", hold_o, 1);
      up_n = 1'b1; wait_ms(5);
      chk("R3 hold clears", hold_o, 0);

      // aborted two-button press
      up_n = 1'b0; dn_n = 1'b0; wait_ms(500);
      chk("R10 hold during two-button", hold_o, 1);
      up_n = 1'b1; wait_ms(ENTRY);
      chk("R4 abort no shutdown", shdn_o, 0);
      chk("R4 hold after abort", hold_o, 1);
      dn_n = 1'b1; wait_ms(5);
      chk("R4 hold clears", hold_o, 0);

      // entry, stay, store-driven exit
      pos_i = 5'd9;
      expect_ev(1, 0);
      up_n = 1'b0; wait_ms(5); dn_n = 1'b0;
      wait_ms(ENTRY + 3);
      chk("R2 shutdown entered", shdn_o, 1);
      wait_ms(100);
      chk("R6 held buttons keep shutdown", shdn_o, 1);
      up_n = 1'b1; dn_n = 1'b1; wait_ms(100);
      chk("R6 release keeps shutdown", shdn_o, 1);
      pos_i = 5'd20; wait_ms(2);
      chk("R5 saved unchanged", restore_pos_o, 9);
      chk("R10 hold in shutdown", hold_o, 1);
      up_n = 1'b0; wait_ms(10); up_n = 1'b1; wait_ms(5);
      store_n = 1'b0; wait_ms(8); store_n = 1'b1; wait_ms(5);
      chk("R7 short lows ignored", shdn_o, 1);
      chk("R5 saved after presses", restore_pos_o, 9);
      expect_ev(2, 9);
      store_n = 1'b0; wait_ms(20);
      chk("R7 store exits", shdn_o, 0);
      store_n = 1'b1; wait_ms(REP + 20);

      // exit by down held: repeat down
      enter_shdn(4);
      expect_ev(2, 4); expect_ev(3, 0);
      dn_n = 1'b0; wait_ms(REP + 40);
      chk("R7 down exits", shdn_o, 0);
      dn_n = 1'b1; wait_ms(5);

      // exit by up released early: no repeat
      enter_shdn(17);
      expect_ev(2, 17);
      up_n = 1'b0; wait_ms(100); up_n = 1'b1; wait_ms(REP + 50);
      chk("R9 early release", shdn_o, 0);

      // exit by up held: repeat up
      enter_shdn(31);
      expect_ev(2, 31); expect_ev(3, 1);
      up_n = 1'b0; wait_ms(REP + 40);
      up_n = 1'b1; wait_ms(10);
      chk("R9 queue drained", exp_q.size(), 0);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (190000) @(negedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule